// File: doc/BRIEF.md
# Link Active-State Power Controller

This block runs beside one port of a serial link and picks the link's power state: fully active, a quick-exit standby that only this port's transmit side enters, or a deeper standby that both ends must agree on. A two-bit policy input sets three things: whether the transmit side may drop into the quick standby, whether this port may ask the partner for the deeper standby, and whether a request from the partner is accepted. A traffic-idle input and two programmable idle thresholds decide when each standby is tried. The device power state overrides the policy: whenever the device is outside its fully-on state, the port asks for the deeper standby on its own.

The partner exchange is modelled as single-cycle pulses: a request to the partner, a positive or negative answer to the partner's request, and the partner's answer to this port's request. Leaving the deeper standby always goes through a recovery phase of fixed length before the link is active again. A block-traffic output tells the transmit scheduler when no packets may be sent.

Top module: `link_pm_ctrl`

## Requirements
- R1: After a synchronous active-low reset the link state is active (code 0), all three pulse outputs are low, and packet blocking is low.
- R2: The transmit standby (state code 1) is entered only when policy bit 0 is 1 and the device state is D0 (code 00), on the clock edge that samples the `l0s_limit_i`-th consecutive idle cycle; any cycle with traffic pending restarts the count, and in standby the first cycle with traffic pending returns the link to active on the next edge.
- R3: With policy bit 1 set and the device in D0, the edge that samples the `l1_limit_i`-th consecutive idle cycle (from active or transmit standby) raises `l1_req_o` for one cycle and moves to the waiting state (code 2); with bit 1 clear no such request is sent.
- R4: A partner request seen in the active or transmit-standby state is answered on the next cycle with `l1_ack_o` if policy bit 1 is 1 or the device is outside D0, moving to the deep standby (code 3); otherwise with `l1_nak_o`, and the state is kept.
- R5: In the waiting state, `l1_ack_in_i` moves the link to deep standby and `l1_nak_in_i` returns it to active.
- R6: While in active or transmit standby with the device outside D0 and no partner request, the port raises `l1_req_o` and moves to the waiting state regardless of policy.
- R7: Deep standby is left only when the device is in D0 and either traffic is pending or deep standby was entered while the device was outside D0; the link then spends exactly `RECOV_CYC` cycles in recovery (code 4) before active. Outside D0 the link stays in deep standby even with traffic pending.
- R8: `pkt_block_o` is high in every state except active; `tx_l0s_o` is high only in transmit standby.
- R9: A partner request arriving in the waiting, deep-standby or recovery state gets no answer.
- R10: At most one of the three pulse outputs is high in any cycle; when a partner request and an own request would coincide, only the answer to the partner is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 2 | Bit 0 allows transmit standby, bit 1 allows deep-standby requests and acceptance |
| dev_state_i | input | 2 | Device power state; 00 is D0, any other code is a reduced state |
| tx_idle_i | input | 1 | High when no transmit traffic is pending |
| l0s_limit_i | input | CNT_W | Consecutive idle cycles before transmit standby |
| l1_limit_i | input | CNT_W | Consecutive idle cycles before a deep-standby request |
| l1_req_in_i | input | 1 | Partner asks for deep standby (pulse) |
| l1_ack_in_i | input | 1 | Partner accepts this port's request (pulse) |
| l1_nak_in_i | input | 1 | Partner rejects this port's request (pulse) |
| l1_req_o | output | 1 | Request to the partner for deep standby (pulse) |
| l1_ack_o | output | 1 | Positive answer to the partner's request (pulse) |
| l1_nak_o | output | 1 | Negative answer to the partner's request (pulse) |
| tx_l0s_o | output | 1 | Transmit side is in standby |
| pkt_block_o | output | 1 | No packets may be sent |
| link_state_o | output | 3 | Current state: 0 active, 1 transmit standby, 2 waiting, 3 deep standby, 4 recovery |

## Verification
The bench builds the block with `CNT_W` = 6 and `RECOV_CYC` = 3, and drives the thresholds at 3 and 5 cycles. The short thresholds let every policy code reach both standby decisions, including the deep-standby request launched from transmit standby, within a few cycles, and the three-cycle recovery makes its exact length visible on both its first and last cycle. A device state of D1 and D3hot exercises the override, the collision between partner request and own request, and the hold in deep standby while traffic is pending.

// File: rtl/lpm_pkg.sv
// Package: shared types for the link power controller.
// Assumes: state codes are visible on link_state_o and must not be reordered.
package lpm_pkg;

    typedef enum logic [2:0] {
        LS_L0     = 3'd0,
        LS_L0S    = 3'd1,
        LS_L1WAIT = 3'd2,
        LS_L1     = 3'd3,
        LS_RECOV  = 3'd4
    } link_st_e;

    localparam logic [1:0] DEV_D0 = 2'b00;

    // Policy bit positions; external software relies on them.
    localparam int POL_L0S_BIT = 0;
    localparam int POL_L1_BIT  = 1;

endpackage

// File: rtl/lpm_idle_cnt.sv
// Module: counts consecutive idle cycles while counting is enabled and
// flags when each of two thresholds is met by the cycle being sampled.
// Assumes: a threshold of zero behaves like one; the count saturates.
module lpm_idle_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             idle_i,
    input  logic [CNT_W-1:0] l0s_lim_i,
    input  logic [CNT_W-1:0] l1_lim_i,
    output logic             hit_l0s_o,
    output logic             hit_l1_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             run;

    // Purpose: next run length, cleared by traffic or when disabled.
    always_comb begin
        run = en_i && idle_i;
        if (!run) begin
            cnt_nxt = '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_nxt = CNT_MAX;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
        end
    end

    // Purpose: hold the run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // Purpose: threshold flags for the cycle being sampled.
    always_comb begin
        hit_l0s_o = run && (cnt_nxt >= l0s_lim_i);
        hit_l1_o  = run && (cnt_nxt >= l1_lim_i);
    end

    AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && idle_i) |=> !hit_l0s_o || (l0s_lim_i <= 1)); // R2

endmodule

// File: rtl/lpm_policy_dec.sv
// Module: turns the policy code and device state into permissions.
// Assumes: every device state other than D0 is treated as reduced.
module lpm_policy_dec
    import lpm_pkg::*;
(
    input  logic [1:0] policy_i,
    input  logic [1:0] dev_state_i,
    output logic       in_d0_o,
    output logic       allow_l0s_o,
    output logic       allow_l1_o,
    output logic       accept_l1_o
);
    // Purpose: derive per-feature permissions.
    always_comb begin
        in_d0_o     = (dev_state_i == DEV_D0);
        allow_l0s_o = policy_i[POL_L0S_BIT] && in_d0_o;
        allow_l1_o  = policy_i[POL_L1_BIT]  && in_d0_o;
        accept_l1_o = policy_i[POL_L1_BIT]  || !in_d0_o;
    end

endmodule

// File: rtl/lpm_recov_timer.sv
// Module: measures the recovery phase; done is high in its last cycle.
// Assumes: RECOV_CYC >= 1; active_i stays high for the whole phase.
module lpm_recov_timer #(
    parameter int RECOV_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic done_o
);
    localparam int RW = $clog2(RECOV_CYC + 1);
    localparam logic [RW-1:0] LAST = RW'(RECOV_CYC - 1);

    logic [RW-1:0] cnt_q;

    // Purpose: count cycles spent in recovery, clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i || done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: flag the final recovery cycle.
    always_comb begin
        done_o = active_i && (cnt_q == LAST);
    end

endmodule

// File: rtl/link_pm_ctrl.sv
// Module: per-port link power state controller. Chooses between active,
// transmit standby and deep standby from the policy code, the idle input
// and the device power state, and runs the pulse handshake with the partner.
// Assumes: partner pulses are one cycle wide and already synchronous.
module link_pm_ctrl
    import lpm_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int RECOV_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_i,
    input  logic [1:0]       dev_state_i,
    input  logic             tx_idle_i,
    input  logic [CNT_W-1:0] l0s_limit_i,
    input  logic [CNT_W-1:0] l1_limit_i,
    input  logic             l1_req_in_i,
    input  logic             l1_ack_in_i,
    input  logic             l1_nak_in_i,
    output logic             l1_req_o,
    output logic             l1_ack_o,
    output logic             l1_nak_o,
    output logic             tx_l0s_o,
    output logic             pkt_block_o,
    output logic [2:0]       link_state_o
);
    link_st_e st_q, st_d;
    logic     sw_q, sw_d;
    logic     req_d, ack_d, nak_d;
    logic     req_q, ack_q, nak_q;
    logic     in_d0, allow_l0s, allow_l1, accept_l1;
    logic     hit_l0s, hit_l1, recov_done, awake;

    assign awake = (st_q == LS_L0) || (st_q == LS_L0S);

    lpm_policy_dec u_pol (
        .policy_i    (policy_i),
        .dev_state_i (dev_state_i),
        .in_d0_o     (in_d0),
        .allow_l0s_o (allow_l0s),
        .allow_l1_o  (allow_l1),
        .accept_l1_o (accept_l1)
    );

    lpm_idle_cnt #(.CNT_W(CNT_W)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (awake),
        .idle_i    (tx_idle_i),
        .l0s_lim_i (l0s_limit_i),
        .l1_lim_i  (l1_limit_i),
        .hit_l0s_o (hit_l0s),
        .hit_l1_o  (hit_l1)
    );

    lpm_recov_timer #(.RECOV_CYC(RECOV_CYC)) u_recov (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (st_q == LS_RECOV),
        .done_o   (recov_done)
    );

    // Purpose: next state and handshake pulses, partner request first.
    always_comb begin
        st_d  = st_q;
        sw_d  = sw_q;
        req_d = 1'b0;
        ack_d = 1'b0;
        nak_d = 1'b0;
        unique case (st_q)
            LS_L0, LS_L0S: begin
                if (l1_req_in_i) begin
                    if (accept_l1) begin
                        ack_d = 1'b1;
                        st_d  = LS_L1;
                        sw_d  = !in_d0;
                    end else begin
                        nak_d = 1'b1;
                        if (st_q == LS_L0S && !tx_idle_i) begin
                            st_d = LS_L0;
                        end
                    end
                end else if (!in_d0) begin
                    req_d = 1'b1;
                    st_d  = LS_L1WAIT;
                end else if (hit_l1 && allow_l1) begin
                    req_d = 1'b1;
                    st_d  = LS_L1WAIT;
                end else if (st_q == LS_L0 && hit_l0s && allow_l0s) begin
                    st_d = LS_L0S;
                end else if (st_q == LS_L0S && !tx_idle_i) begin
                    st_d = LS_L0;
                end
            end
            LS_L1WAIT: begin
                if (l1_ack_in_i) begin
                    st_d = LS_L1;
                    sw_d = !in_d0;
                end else if (l1_nak_in_i) begin
                    st_d = LS_L0;
                end
            end
            LS_L1: begin
                if (in_d0 && (!tx_idle_i || sw_q)) begin
                    st_d = LS_RECOV;
                end
            end
            LS_RECOV: begin
                sw_d = 1'b0;
                if (recov_done) begin
                    st_d = LS_L0;
                end
            end
            default: begin
                st_d = LS_L0;
                sw_d = 1'b0;
            end
        endcase
    end

    // Purpose: state, software-entry flag and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LS_L0;
            sw_q  <= 1'b0;
            req_q <= 1'b0;
            ack_q <= 1'b0;
            nak_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            sw_q  <= sw_d;
            req_q <= req_d;
            ack_q <= ack_d;
            nak_q <= nak_d;
        end
    end

    // Purpose: drive the outputs from registered state.
    always_comb begin
        l1_req_o     = req_q;
        l1_ack_o     = ack_q;
        l1_nak_o     = nak_q;
        tx_l0s_o     = (st_q == LS_L0S);
        pkt_block_o  = (st_q != LS_L0);
        link_state_o = st_q;
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({l1_req_o, l1_ack_o, l1_nak_o}) <= 1); // R10

    AST_ACK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        l1_ack_o |-> $past(policy_i[POL_L1_BIT] || dev_state_i != DEV_D0)); // R4

    AST_NAK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        l1_nak_o |-> $past(!policy_i[POL_L1_BIT] && dev_state_i == DEV_D0)); // R4

    AST_L0S_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_l0s_o) |-> $past(policy_i[POL_L0S_BIT] && dev_state_i == DEV_D0)); // R2

    AST_L1_EXIT_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_state_o) == 3'd3) |-> (link_state_o == 3'd3 || link_state_o == 3'd4)); // R7

    AST_SW_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && dev_state_i != DEV_D0 && !l1_req_in_i) |=> l1_req_o); // R6

    AST_NO_LATE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req_in_i && !awake) |=> !(l1_ack_o || l1_nak_o)); // R9

endmodule

// File: tb/link_pm_ctrl_tb_top.sv
// Bench: directed scenarios, one task each, every task checks its results.
module link_pm_ctrl_tb_top;
    localparam int CW = 6;
    localparam int RC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    policy = 2'b00;
    logic [1:0]    dev = 2'b00;
    logic          idle = 1'b0;
    logic [CW-1:0] l0s_lim = CW'(3);
    logic [CW-1:0] l1_lim = CW'(5);
    logic          p_req = 1'b0;
    logic          p_ack = 1'b0;
    logic          p_nak = 1'b0;
    logic          req_o, ack_o, nak_o, l0s_o, blk_o;
    logic [2:0]    st_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    link_pm_ctrl #(.CNT_W(CW), .RECOV_CYC(RC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .policy_i     (policy),
        .dev_state_i  (dev),
        .tx_idle_i    (idle),
        .l0s_limit_i  (l0s_lim),
        .l1_limit_i   (l1_lim),
        .l1_req_in_i  (p_req),
        .l1_ack_in_i  (p_ack),
        .l1_nak_in_i  (p_nak),
        .l1_req_o     (req_o),
        .l1_ack_o     (ack_o),
        .l1_nak_o     (nak_o),
        .tx_l0s_o     (l0s_o),
        .pkt_block_o  (blk_o),
        .link_state_o (st_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 state", st_o, 0);
        chk("R1 pulses", {req_o, ack_o, nak_o}, 0);
        chk("R1 block", blk_o, 0);
    endtask

    task automatic t_l0s();
        policy = 2'b01;
        idle = 1'b1;
        tick(); tick();
        chk("R2 before limit", st_o, 0);
        tick();
        chk("R2 enter standby", st_o, 1);
        chk("R8 tx standby flag", l0s_o, 1);
        chk("R8 block in standby", blk_o, 1);
        repeat (4) tick();
        chk("R3 no request without bit1", st_o, 1);
        idle = 1'b0;
        tick();
        chk("R2 leave on traffic", st_o, 0);
        chk("R8 block clear", blk_o, 0);
        idle = 1'b1; tick(); tick();
        idle = 1'b0; tick();
        idle = 1'b1; tick(); tick();
        chk("R2 broken run", st_o, 0);
        tick();
        chk("R2 new full run", st_o, 1);
        idle = 1'b0;
        tick();
    endtask

    task automatic t_off();
        int seen = 0;
        policy = 2'b00;
        idle = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick();
            seen += req_o;
        end
        chk("R2 policy 00 stays active", st_o, 0);
        chk("R3 policy 00 no request", seen, 0);
        idle = 1'b0;
        tick();
    endtask

    task automatic t_aspm();
        policy = 2'b10;
        idle = 1'b1;
        repeat (4) tick();
        chk("R2 no standby with bit0 clear", st_o, 0);
        tick();
        chk("R3 request state", st_o, 2);
        chk("R3 request pulse", req_o, 1);
        tick();
        chk("R10 request one cycle", req_o, 0);
        p_ack = 1'b1; tick(); p_ack = 1'b0;
        chk("R5 ack enters deep", st_o, 3);
        tick(); tick();
        chk("R7 stay while idle", st_o, 3);
        idle = 1'b0;
        tick();
        chk("R7 recovery first", st_o, 4);
        chk("R8 block in recovery", blk_o, 1);
        tick(); tick();
        chk("R7 recovery last", st_o, 4);
        tick();
        chk("R7 back to active", st_o, 0);
    endtask

    task automatic t_nak();
        policy = 2'b11;
        idle = 1'b1;
        repeat (3) tick();
        chk("R2 standby with 11", st_o, 1);
        tick(); tick();
        chk("R3 request from standby", req_o, 1);
        p_nak = 1'b1; tick(); p_nak = 1'b0;
        chk("R5 nak returns active", st_o, 0);
        repeat (3) tick();
        chk("R2 count restarts", st_o, 1);
        idle = 1'b0;
        tick();
    endtask

    task automatic t_partner();
        policy = 2'b01;
        idle = 1'b0;
        p_req = 1'b1; tick(); p_req = 1'b0;
        chk("R4 nak pulse", nak_o, 1);
        chk("R4 nak no ack", ack_o, 0);
        chk("R4 nak keeps active", st_o, 0);
        policy = 2'b10;
        idle = 1'b1;
        p_req = 1'b1; tick(); p_req = 1'b0;
        chk("R4 ack pulse", ack_o, 1);
        chk("R4 ack enters deep", st_o, 3);
        p_req = 1'b1; tick(); p_req = 1'b0;
        chk("R9 no answer in deep", {ack_o, nak_o}, 0);
        idle = 1'b0;
        tick();
        chk("R7 traffic wakes", st_o, 4);
        repeat (3) tick();
        chk("R7 active after recovery", st_o, 0);
        policy = 2'b00;
        dev = 2'b01;
        p_req = 1'b1; tick(); p_req = 1'b0;
        chk("R4 reduced state accepts", ack_o, 1);
        chk("R10 own request suppressed", req_o, 0);
        chk("R4 deep after accept", st_o, 3);
        repeat (3) tick();
        chk("R7 held outside D0", st_o, 3);
        dev = 2'b00;
        idle = 1'b1;
        tick();
        chk("R7 D0 return wakes", st_o, 4);
        repeat (3) tick();
        chk("R7 active after D0 return", st_o, 0);
    endtask

    task automatic t_sw();
        policy = 2'b00;
        dev = 2'b11;
        idle = 1'b0;
        tick();
        chk("R6 forced request", req_o, 1);
        chk("R6 waiting state", st_o, 2);
        chk("R8 waiting no tx standby", l0s_o, 0);
        chk("R8 waiting blocks", blk_o, 1);
        p_req = 1'b1; tick(); p_req = 1'b0;
        chk("R9 no answer while waiting", {ack_o, nak_o}, 0);
        chk("R9 state kept", st_o, 2);
        p_ack = 1'b1; tick(); p_ack = 1'b0;
        chk("R5 ack enters deep", st_o, 3);
        dev = 2'b00;
        idle = 1'b1;
        tick();
        chk("R7 wake after software entry", st_o, 4);
        repeat (3) tick();
        chk("R7 done", st_o, 0);
    endtask

    initial begin
        t_reset();
        t_l0s();
        t_off();
        t_aspm();
        t_nak();
        t_partner();
        t_sw();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule